// File: doc/BRIEF.md
# Test Pin Source Selector with Serial-Clock Divider Bypass

This block chooses what a single-ended test pin carries, using a 3-bit test code. The sources are the serial configuration data bit, a constant one or zero, the reference tick rate divided by 16, the feedback (M) counter pulse, the main output, and the main output divided by 4. The block also owns the feedback M counter and the post (N) divider that produces the main output. It runs in one clock domain. Each of the reference, synthesized and serial clocks appears as a one-cycle tick enable.

One test code selects bypass mode. In that mode the M counter and the post divider take their ticks from the serial clock enable, so a slow board-level clock can drive the clock tree directly. The post divider output then drives the main output and the test pin shows the M counter pulse. In every other mode both dividers are ticked by the synthesized-output enable.

Top module: `testpin_bypass_sel`

## Requirements
- R1: While reset is high, and on the first cycle after it falls with test code 000 and the data bit at 0, test_o and fout_o are both 0.
- R2: Test code 000 puts sr_bit on test_o one clock later. Code 001 drives test_o to 1 one clock later, and code 101 drives it to 0 one clock later.
- R3: Test code 010 shows a square wave on test_o that toggles once every 8 ref_en ticks. Without ref_en ticks, test_o holds its value.
- R4: Test code 011 shows the M counter on test_o. The counter gives one high cycle for every m_val ticks of its source, and outside bypass the source is syn_en.
- R5: Test code 110 is bypass mode. Both dividers are ticked by sclk_en, syn_en has no effect, and test_o shows the M counter pulse.
- R6: An m_val of 0 divides by 1, so there is one pulse per input tick.
- R7: n_code values 00, 01, 10 and 11 set N to 1, 2, 4 and 8. fout_o is a square wave whose period is 2×N divider ticks. With N = 1 it toggles on every tick, which is half the tick rate.
- R8: When n_code or the test code changes, fout_o is 0 on the next cycle. Its first rise then comes N divider ticks later.
- R9: Test code 100 puts fout_o on test_o, delayed by one clock.
- R10: Test code 111 shows fout_o divided by 4 on test_o. This signal toggles once for every two rising edges of fout_o.
- R11: Outside bypass mode, sclk_en has no effect on the dividers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tcode | input | 3 | Test code selecting the test pin source and the divider clocking |
| m_val | input | 9 | M counter modulus (0 is treated as 1) |
| n_code | input | 2 | Post divider code (N = 1, 2, 4, 8) |
| sr_bit | input | 1 | Serial configuration data bit shown under code 000 |
| ref_en | input | 1 | Reference clock tick enable |
| syn_en | input | 1 | Synthesized clock tick enable |
| sclk_en | input | 1 | Serial clock tick enable |
| test_o | output | 1 | Registered test pin |
| fout_o | output | 1 | Registered main (post divider) output |

## Verification
test_o follows its selected source one clock after that source's register changes. That puts a constant or the data bit one clock after the code is applied, and the M pulse two clocks after the tick that ends a count. fout_o changes on the edge that consumes a tick, and it is forced to 0 on the first edge after a change of N or of the test code. Inputs and tick enables are driven on the falling edge and outputs are sampled on later falling edges, so every check counts whole clock edges. Divider ratios are checked by counting highs and transitions over windows that are whole multiples of each period, so the result does not depend on the starting phase.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  typedef enum logic [2:0] {
    TC_SHIFT  = 3'b000,
    TC_ONE    = 3'b001,
    TC_REF16  = 3'b010,
    TC_MCNT   = 3'b011,
    TC_FOUT   = 3'b100,
    TC_ZERO   = 3'b101,
    TC_BYPASS = 3'b110,
    TC_FOUT4  = 3'b111
  } tcode_e;
endpackage

// File: rtl/tsel_ref_div.sv
module tsel_ref_div #(
  parameter int LOG2 = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic i_tick,
  output logic o_sq
);
  logic [LOG2-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (i_tick) cnt <= cnt + 1'b1;
  end

  assign o_sq = cnt[LOG2-1];

  // R3: the divided wave only moves on a reference tick
  p_ref_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !i_tick |=> $stable(o_sq));
endmodule

// File: rtl/tsel_m_counter.sv
module tsel_m_counter #(
  parameter int M_W = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           i_tick,
  input  logic           i_restart,
  input  logic [M_W-1:0] i_m,
  output logic           o_pulse
);
  logic [M_W-1:0] cnt;
  logic [M_W-1:0] m_eff;

  assign m_eff = (i_m == '0) ? M_W'(1) : i_m;

  always_ff @(posedge clk) begin
    if (rst || i_restart) begin
      cnt     <= '0;
      o_pulse <= 1'b0;
    end else begin
      o_pulse <= 1'b0;
      if (i_tick) begin
        if (cnt >= m_eff - 1'b1) begin
          cnt     <= '0;
          o_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: a pulse is always the result of a tick on the previous edge
  p_pulse_after_tick_r4: assert property (@(posedge clk) disable iff (rst)
    o_pulse |-> $past(i_tick));
  // R6: with a modulus of 0 or 1 every tick yields a pulse
  p_div_one_r6: assert property (@(posedge clk) disable iff (rst)
    (i_tick && !i_restart && i_m <= M_W'(1)) |=> o_pulse);
endmodule

// File: rtl/tsel_post_div.sv
module tsel_post_div #(
  parameter int N_W = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           i_tick,
  input  logic           i_restart,
  input  logic [N_W-1:0] i_ncode,
  output logic           o_sq,
  output logic           o_q4
);
  localparam int CNT_W = (1 << N_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic [1:0]       rise_cnt;

  assign half_m1 = (CNT_W'(1) << i_ncode) - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || i_restart) begin
      cnt      <= '0;
      o_sq     <= 1'b0;
      rise_cnt <= '0;
    end else if (i_tick) begin
      if (cnt >= half_m1) begin
        cnt  <= '0;
        o_sq <= ~o_sq;
        if (!o_sq) rise_cnt <= rise_cnt + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign o_q4 = rise_cnt[1];

  // R7: the square wave only moves on a tick or a restart
  p_sq_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    (o_sq != $past(o_sq)) |-> $past(i_tick || i_restart));
  // R8: a restart leaves the output low
  p_restart_low_r8: assert property (@(posedge clk) disable iff (rst)
    i_restart |=> !o_sq);
  // R10: the divide-by-4 output only moves when the main output rises
  p_q4_on_rise_r10: assert property (@(posedge clk) disable iff (rst)
    (o_q4 != $past(o_q4) && !$past(i_restart)) |-> $rose(o_sq));
endmodule

// File: rtl/testpin_bypass_sel.sv
module testpin_bypass_sel
  import tsel_pkg::*;
#(
  parameter int M_W      = 9,
  parameter int N_W      = 2,
  parameter int REF_LOG2 = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     tcode,
  input  logic [M_W-1:0] m_val,
  input  logic [N_W-1:0] n_code,
  input  logic           sr_bit,
  input  logic           ref_en,
  input  logic           syn_en,
  input  logic           sclk_en,
  output logic           test_o,
  output logic           fout_o
);
  tcode_e         mode;
  logic           bypass;
  logic           div_tick;
  logic [2:0]     tcode_q;
  logic [M_W-1:0] m_q;
  logic [N_W-1:0] n_q;
  logic           restart_p;
  logic           restart_m;
  logic           ref_sq;
  logic           m_pulse;
  logic           p_sq;
  logic           p_q4;
  logic           test_d;

  assign mode     = tcode_e'(tcode);
  assign bypass   = (mode == TC_BYPASS);
  assign div_tick = bypass ? sclk_en : syn_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcode_q <= '0;
      m_q     <= '0;
      n_q     <= '0;
    end else begin
      tcode_q <= tcode;
      m_q     <= m_val;
      n_q     <= n_code;
    end
  end

  assign restart_p = (n_code != n_q) || (tcode != tcode_q);
  assign restart_m = (m_val != m_q) || (tcode != tcode_q);

  tsel_ref_div #(.LOG2(REF_LOG2)) u_ref (
    .clk(clk), .rst(rst), .i_tick(ref_en), .o_sq(ref_sq)
  );

  tsel_m_counter #(.M_W(M_W)) u_mcnt (
    .clk(clk), .rst(rst), .i_tick(div_tick), .i_restart(restart_m),
    .i_m(m_val), .o_pulse(m_pulse)
  );

  tsel_post_div #(.N_W(N_W)) u_post (
    .clk(clk), .rst(rst), .i_tick(div_tick), .i_restart(restart_p),
    .i_ncode(n_code), .o_sq(p_sq), .o_q4(p_q4)
  );

  always_comb begin
    case (mode)
      TC_SHIFT:  test_d = sr_bit;
      TC_ONE:    test_d = 1'b1;
      TC_REF16:  test_d = ref_sq;
      TC_MCNT:   test_d = m_pulse;
      TC_FOUT:   test_d = p_sq;
      TC_ZERO:   test_d = 1'b0;
      TC_BYPASS: test_d = m_pulse;
      TC_FOUT4:  test_d = p_q4;
      default:   test_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) test_o <= 1'b0;
    else     test_o <= test_d;
  end

  assign fout_o = p_sq;

  p_const_one_r2: assert property (@(posedge clk) disable iff (rst)
    (tcode == 3'b001) |=> test_o);
  p_const_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (tcode == 3'b101) |=> !test_o);
  p_shift_bit_r2: assert property (@(posedge clk) disable iff (rst)
    (tcode == 3'b000) |=> (test_o == $past(sr_bit)));
  p_fout_copy_r9: assert property (@(posedge clk) disable iff (rst)
    (tcode == 3'b100) |=> (test_o == $past(fout_o)));
  p_bypass_no_syn_r5: assert property (@(posedge clk) disable iff (rst)
    (bypass && !sclk_en && !restart_p) |=> $stable(fout_o));
  p_normal_no_sclk_r11: assert property (@(posedge clk) disable iff (rst)
    (!bypass && !syn_en && !restart_p) |=> $stable(fout_o));
endmodule

// File: tb/test_testpin_bypass_sel.sv
module test_testpin_bypass_sel;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] tcode = 3'b000;
  logic [8:0] m_val = 9'd0;
  logic [1:0] n_code = 2'b00;
  logic       sr_bit = 1'b0;
  logic       ref_en = 1'b0;
  logic       syn_en = 1'b0;
  logic       sclk_en = 1'b0;
  logic       test_o;
  logic       fout_o;

  int checks = 0;
  int fails  = 0;
  int ref_pat = 0, syn_pat = 0, sclk_pat = 0;
  bit ph = 1'b0;

  always #5 clk = ~clk;

  testpin_bypass_sel i_testpin_bypass_sel (
    .clk(clk), .rst(rst), .tcode(tcode), .m_val(m_val), .n_code(n_code),
    .sr_bit(sr_bit), .ref_en(ref_en), .syn_en(syn_en), .sclk_en(sclk_en),
    .test_o(test_o), .fout_o(fout_o)
  );

  // tick drivers: 0 = off, 1 = every cycle, 2 = every other cycle
  initial forever begin
    @(negedge clk);
    ph = ~ph;
    ref_en  = (ref_pat == 1)  || (ref_pat == 2 && ph);
    syn_en  = (syn_pat == 1)  || (syn_pat == 2 && ph);
    sclk_en = (sclk_pat == 1) || (sclk_pat == 2 && ph);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic run(input int n, output int hi_t, output int tr_t,
                     output int hi_f, output int tr_f, output int fol_bad);
    logic pt, pf;
    pt = test_o; pf = fout_o;
    hi_t = 0; tr_t = 0; hi_f = 0; tr_f = 0; fol_bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (test_o) hi_t++;
      if (test_o != pt) tr_t++;
      if (test_o != pf) fol_bad++;
      if (fout_o) hi_f++;
      if (fout_o != pf) tr_f++;
      pt = test_o; pf = fout_o;
    end
  endtask

  task automatic t_reset;
    settle(3);
    check(test_o == 1'b0 && fout_o == 1'b0, "R1 in reset", test_o, 0);
    rst = 1'b0;
    settle(1);
    check(test_o == 1'b0 && fout_o == 1'b0, "R1 after reset", fout_o, 0);
  endtask

  task automatic t_const;
    tcode = 3'b001; settle(1);
    check(test_o == 1'b1, "R2 code 001", test_o, 1);
    tcode = 3'b101; settle(1);
    check(test_o == 1'b0, "R2 code 101", test_o, 0);
    tcode = 3'b000; sr_bit = 1'b1; settle(1);
    check(test_o == 1'b1, "R2 data bit high", test_o, 1);
    sr_bit = 1'b0; settle(1);
    check(test_o == 1'b0, "R2 data bit low", test_o, 0);
  endtask

  task automatic t_ref;
    int ht, tt, hf, tf, fb;
    tcode = 3'b010; ref_pat = 1; settle(4);
    run(64, ht, tt, hf, tf, fb);
    check(tt == 8, "R3 ref every cycle", tt, 8);
    ref_pat = 2; settle(4);
    run(64, ht, tt, hf, tf, fb);
    check(tt == 4, "R3 ref alternate", tt, 4);
    ref_pat = 0; settle(4);
    run(40, ht, tt, hf, tf, fb);
    check(tt == 0, "R3 no ticks hold", tt, 0);
  endtask

  task automatic t_mnorm;
    int ht, tt, hf, tf, fb;
    tcode = 3'b011; m_val = 9'd3; syn_pat = 1; sclk_pat = 1; settle(8);
    run(96, ht, tt, hf, tf, fb);
    check(ht == 32, "R4 M=3 pulses", ht, 32);
    syn_pat = 0; settle(4);
    run(60, ht, tt, hf, tf, fb);
    check(ht == 0, "R11 sclk ignored by M counter", ht, 0);
    check(tf == 0, "R11 sclk ignored by post divider", tf, 0);
  endtask

  task automatic t_bypass;
    int ht, tt, hf, tf, fb;
    tcode = 3'b110; m_val = 9'd5; n_code = 2'b00;
    sclk_pat = 1; syn_pat = 1; settle(10);
    run(100, ht, tt, hf, tf, fb);
    check(ht == 20, "R5 bypass M=5 pulses", ht, 20);
    check(tf == 100, "R7 N=1 toggles every tick", tf, 100);
    sclk_pat = 0; settle(4);
    run(60, ht, tt, hf, tf, fb);
    check(ht == 0, "R5 syn ignored M", ht, 0);
    check(tf == 0, "R5 syn ignored fout", tf, 0);
    m_val = 9'd0; sclk_pat = 2; syn_pat = 0; settle(8);
    run(100, ht, tt, hf, tf, fb);
    check(ht == 50, "R6 M=0 divide by one", ht, 50);
  endtask

  task automatic t_ndiv;
    int ht, tt, hf, tf, fb;
    tcode = 3'b110; sclk_pat = 1; syn_pat = 0;
    for (int nc = 0; nc < 4; nc++) begin
      n_code = 2'(nc); settle(20);
      run(128, ht, tt, hf, tf, fb);
      check(tf == (128 >> nc), "R7 N code transitions", tf, 128 >> nc);
      check(hf == 64, "R7 N code duty", hf, 64);
    end
  endtask

  task automatic t_restart;
    n_code = 2'b11; settle(12);
    check(fout_o == 1'b1, "R7 N=8 high after 8 ticks", fout_o, 1);
    n_code = 2'b01; settle(1);
    check(fout_o == 1'b0, "R8 N change clears", fout_o, 0);
    settle(1);
    check(fout_o == 1'b0, "R8 N change one tick", fout_o, 0);
    settle(1);
    check(fout_o == 1'b1, "R8 N change first rise", fout_o, 1);
    settle(4);
    syn_pat = 1; tcode = 3'b100; settle(1);
    check(fout_o == 1'b0, "R8 code change clears", fout_o, 0);
    settle(1);
    check(fout_o == 1'b0, "R8 code change one tick", fout_o, 0);
    settle(1);
    check(fout_o == 1'b1, "R8 code change first rise", fout_o, 1);
  endtask

  task automatic t_fout;
    int ht, tt, hf, tf, fb;
    tcode = 3'b100; n_code = 2'b00; syn_pat = 1; sclk_pat = 0; settle(6);
    run(40, ht, tt, hf, tf, fb);
    check(fb == 0, "R9 test follows fout", fb, 0);
    check(tf == 40, "R9 fout toggling", tf, 40);
    syn_pat = 0; sclk_pat = 1; settle(4);
    run(40, ht, tt, hf, tf, fb);
    check(tf == 0, "R11 sclk ignored in code 100", tf, 0);
  endtask

  task automatic t_div4;
    int ht, tt, hf, tf, fb;
    tcode = 3'b111; n_code = 2'b00; syn_pat = 1; sclk_pat = 0; settle(12);
    run(64, ht, tt, hf, tf, fb);
    check(tt == 16, "R10 fout/4 with N=1", tt, 16);
    n_code = 2'b01; settle(20);
    run(64, ht, tt, hf, tf, fb);
    check(tt == 8, "R10 fout/4 with N=2", tt, 8);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_const();
    t_ref();
    t_mnorm();
    t_bypass();
    t_ndiv();
    t_restart();
    t_fout();
    t_div4();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule